// File: doc/BRIEF.md
# Dual-Mode Peripheral Port

This block lets a host reach simple board peripherals through one set of pins. A host-side register file chooses the mode of the pins. In plain pin mode, every pin is a general-purpose input/output. Each pin has an output value bit and a drive-enable bit, and the host can read back the live level of every pin. In bus mode, the low eight pins form a multiplexed address/data bus and the next three pins carry an address strobe, an active-low read strobe and an active-low write strobe. Through these, an 8-bit address reaches up to 256 byte-wide peripheral registers.

The host first loads a target address. A write to the data register then starts a bus write cycle, and a read of the data register starts a bus read cycle. The byte captured by a read cycle is held in a separate readback register. A busy flag stays set for the whole bus cycle.

Two interrupt inputs sit alongside the port. Each passes through a synchroniser, and every rising or falling edge sets a sticky status bit. A mask gates the status bits onto a single interrupt request, and the synchronised levels can be read back.

Top module: `periph_port`

## Requirements
- R1: After reset, the mode register is 0, every output value and drive-enable bit is 0, the busy flag is 0, the status and mask bits are 0 and the request output is low.
- R2: With the mode register bit 0 clear, pin i drives the bit i of the output-value register (offset 1) onto its output and its enable comes from bit i of the drive-enable register (offset 2). Both registers read back as written.
- R3: Offset 3 reads the current level of every pin, with no register delay.
- R4: In bus mode, a write to the data register (offset 5) first drives the address from offset 4 on pins 7..0 with the address strobe (pin 8) high for 2 clocks. It then drives the written byte with the write strobe (pin 10) low for STROBE clocks, and then returns to idle.
- R5: In bus mode, a read of offset 5 drives the address with the address strobe for 2 clocks and then releases pins 7..0. It then holds the read strobe (pin 9) low for STROBE clocks and captures pins 7..0 on the last of those clocks into the readback register (offset 6).
- R6: Bit 0 of offset 7 is 1 for exactly the 2+STROBE clocks of a bus cycle. Writes and reads of offset 5 made while it is 1 start nothing and leave the bus unaffected.
- R7: In bus mode with no cycle running, pins 10..8 are driven as 1,1,0 (write strobe, read strobe, address strobe) and pins 7..0 are not driven.
- R8: With the mode bit clear, accesses to offset 5 start no bus cycle and leave the busy flag at 0.
- R9: An interrupt input is synchronised over two clocks. Each rising or falling edge then sets its status bit (offset 8, bit n for input n). Writing a 1 to a status bit clears it, and a status bit falls only through such a write.
- R10: The request output is high exactly when some status bit has its mask bit (offset 9) set. With all mask bits clear, it stays low.
- R11: Offset 10 reads the synchronised level of each interrupt input.
- R12: Writes to the mode register (offset 0) made while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one clock per access |
| hst_rd | input | 1 | Host read strobe, one clock per access |
| hst_addr | input | 4 | Host register offset |
| hst_wdata | input | NPIN | Host write data |
| hst_rdata | output | NPIN | Host read data for hst_addr, combinational |
| pin_in | input | NPIN | Levels seen on the pins |
| pin_out | output | NPIN | Values driven on the pins |
| pin_oe | output | NPIN | Per-pin drive enable |
| int_in | input | NIRQ | Asynchronous interrupt inputs |
| irq | output | 1 | Masked interrupt request |

## Verification
The checker takes it for granted that the host strobes each register access for a single clock and that hst_addr is stable while a strobe is high. Under that assumption, the only cause of a falling status bit is a host write to offset 8. The stimulus keeps to this: every access is a one-cycle pulse driven away from the clock edge. Interrupt inputs are changed only after the previous edge has passed the synchroniser, and the bench waits enough clocks before reading status so that no two edges merge.

// File: rtl/periph_port_pkg.sv
package periph_port_pkg;

  typedef enum logic [3:0] {
    RA_CTRL  = 4'd0,
    RA_GOUT  = 4'd1,
    RA_GOE   = 4'd2,
    RA_GIN   = 4'd3,
    RA_BADDR = 4'd4,
    RA_BDATA = 4'd5,
    RA_BRDBK = 4'd6,
    RA_STAT  = 4'd7,
    RA_ISTAT = 4'd8,
    RA_IMASK = 4'd9,
    RA_ILVL  = 4'd10
  } reg_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_WR,
    SQ_RD
  } seq_state_e;

  localparam int unsigned AD_W    = 8;
  localparam int unsigned PIN_ALE = 8;
  localparam int unsigned PIN_RDN = 9;
  localparam int unsigned PIN_WRN = 10;

endpackage

// File: rtl/ppt_irq.sv
module ppt_irq #(
  parameter int unsigned NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] int_in,
  input  logic [NIRQ-1:0] clr,
  output logic [NIRQ-1:0] stat,
  output logic [NIRQ-1:0] lvl
);

  for (genvar n = 0; n < NIRQ; n++) begin : g_ch
    logic s1_q, s2_q, prev_q, st_q;
    logic st_d, edge_hit;

    assign edge_hit = s2_q ^ prev_q;

    always_comb begin
      st_d = st_q;
      if (clr[n]) st_d = 1'b0;
      if (edge_hit) st_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
        st_q   <= 1'b0;
      end else begin
        s1_q   <= int_in[n];
        s2_q   <= s1_q;
        prev_q <= s2_q;
        st_q   <= st_d;
      end
    end

    assign stat[n] = st_q;
    assign lvl[n]  = s2_q;
  end

endmodule

// File: rtl/ppt_bus_seq.sv
module ppt_bus_seq
  import periph_port_pkg::*;
#(
  parameter int unsigned STROBE  = 3,
  parameter int unsigned ALE_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_wr,
  input  logic            launch_rd,
  input  logic [AD_W-1:0] addr,
  input  logic [AD_W-1:0] wdata,
  input  logic [AD_W-1:0] ad_in,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            busy,
  output logic [AD_W-1:0] rdback
);

  localparam int unsigned MAXC = (STROBE > ALE_CYC) ? STROBE : ALE_CYC;
  localparam int unsigned CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] ALE_LAST = CW'(ALE_CYC - 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STROBE - 1);

  seq_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            isw_q, isw_d;
  logic [AD_W-1:0] addr_q, addr_d;
  logic [AD_W-1:0] data_q, data_d;
  logic [AD_W-1:0] rdb_q, rdb_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    isw_d  = isw_q;
    addr_d = addr_q;
    data_d = data_q;
    rdb_d  = rdb_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (launch_wr || launch_rd) begin
          st_d   = SQ_ADDR;
          cnt_d  = '0;
          isw_d  = launch_wr;
          addr_d = addr;
          data_d = wdata;
        end
      end
      SQ_ADDR: begin
        if (cnt_q == ALE_LAST) begin
          st_d  = isw_q ? SQ_WR : SQ_RD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_WR, SQ_RD: begin
        if (cnt_q == STB_LAST) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
          if (st_q == SQ_RD) rdb_d = ad_in;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      isw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdb_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      isw_q  <= isw_d;
      addr_q <= addr_d;
      data_q <= data_d;
      rdb_q  <= rdb_d;
    end
  end

  always_comb begin
    ale    = (st_q == SQ_ADDR);
    wr_n   = (st_q != SQ_WR);
    rd_n   = (st_q != SQ_RD);
    ad_oe  = (st_q == SQ_ADDR) || (st_q == SQ_WR);
    busy   = (st_q != SQ_IDLE);
    ad_out = '0;
    if (st_q == SQ_ADDR) ad_out = addr_q;
    else if (st_q == SQ_WR) ad_out = data_q;
  end

  assign rdback = rdb_q;

endmodule

// File: rtl/ppt_regs.sv
module ppt_regs
  import periph_port_pkg::*;
#(
  parameter int unsigned NPIN = 11,
  parameter int unsigned NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_wr,
  input  logic            hst_rd,
  input  logic [3:0]      hst_addr,
  input  logic [NPIN-1:0] hst_wdata,
  output logic [NPIN-1:0] hst_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic            busy,
  input  logic [AD_W-1:0] rdback,
  input  logic [NIRQ-1:0] irq_stat,
  input  logic [NIRQ-1:0] irq_lvl,
  output logic            mode,
  output logic [NPIN-1:0] gpio_out,
  output logic [NPIN-1:0] gpio_oe,
  output logic [AD_W-1:0] bus_addr,
  output logic [AD_W-1:0] bus_wdata,
  output logic            launch_wr,
  output logic            launch_rd,
  output logic [NIRQ-1:0] irq_mask,
  output logic [NIRQ-1:0] stat_clr
);

  logic            mode_q, mode_d;
  logic [NPIN-1:0] gout_q, gout_d;
  logic [NPIN-1:0] goe_q, goe_d;
  logic [AD_W-1:0] badr_q, badr_d;
  logic [NIRQ-1:0] msk_q, msk_d;
  logic            wr_ctrl, wr_gout, wr_goe, wr_badr, wr_msk, hit_data;

  always_comb begin
    wr_ctrl  = hst_wr && (hst_addr == RA_CTRL) && !busy;
    wr_gout  = hst_wr && (hst_addr == RA_GOUT);
    wr_goe   = hst_wr && (hst_addr == RA_GOE);
    wr_badr  = hst_wr && (hst_addr == RA_BADDR);
    wr_msk   = hst_wr && (hst_addr == RA_IMASK);
    hit_data = (hst_addr == RA_BDATA) && mode_q && !busy;
    launch_wr = hit_data && hst_wr;
    launch_rd = hit_data && hst_rd && !hst_wr;
    stat_clr  = (hst_wr && (hst_addr == RA_ISTAT)) ? hst_wdata[NIRQ-1:0] : '0;
  end

  always_comb begin
    mode_d = wr_ctrl ? hst_wdata[0]            : mode_q;
    gout_d = wr_gout ? hst_wdata               : gout_q;
    goe_d  = wr_goe  ? hst_wdata               : goe_q;
    badr_d = wr_badr ? hst_wdata[AD_W-1:0]     : badr_q;
    msk_d  = wr_msk  ? hst_wdata[NIRQ-1:0]     : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      gout_q <= '0;
      goe_q  <= '0;
      badr_q <= '0;
      msk_q  <= '0;
    end else begin
      mode_q <= mode_d;
      gout_q <= gout_d;
      goe_q  <= goe_d;
      badr_q <= badr_d;
      msk_q  <= msk_d;
    end
  end

  always_comb begin
    hst_rdata = '0;
    unique case (hst_addr)
      RA_CTRL:  hst_rdata[0]           = mode_q;
      RA_GOUT:  hst_rdata              = gout_q;
      RA_GOE:   hst_rdata              = goe_q;
      RA_GIN:   hst_rdata              = pin_in;
      RA_BADDR: hst_rdata[AD_W-1:0]    = badr_q;
      RA_BRDBK: hst_rdata[AD_W-1:0]    = rdback;
      RA_STAT:  hst_rdata[0]           = busy;
      RA_ISTAT: hst_rdata[NIRQ-1:0]    = irq_stat;
      RA_IMASK: hst_rdata[NIRQ-1:0]    = msk_q;
      RA_ILVL:  hst_rdata[NIRQ-1:0]    = irq_lvl;
      default:  hst_rdata              = '0;
    endcase
  end

  assign mode      = mode_q;
  assign gpio_out  = gout_q;
  assign gpio_oe   = goe_q;
  assign bus_addr  = badr_q;
  assign bus_wdata = hst_wdata[AD_W-1:0];
  assign irq_mask  = msk_q;

endmodule

// File: rtl/periph_port.sv
module periph_port
  import periph_port_pkg::*;
#(
  parameter int unsigned NPIN   = 11,
  parameter int unsigned NIRQ   = 2,
  parameter int unsigned STROBE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_wr,
  input  logic            hst_rd,
  input  logic [3:0]      hst_addr,
  input  logic [NPIN-1:0] hst_wdata,
  output logic [NPIN-1:0] hst_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NIRQ-1:0] int_in,
  output logic            irq
);

  logic            mode;
  logic [NPIN-1:0] gpio_out, gpio_oe;
  logic [AD_W-1:0] bus_addr, bus_wdata, ad_out, rdback;
  logic            launch_wr, launch_rd;
  logic            ad_oe, bus_ale, bus_rd_n, bus_wr_n, busy;
  logic [NIRQ-1:0] irq_stat, irq_lvl, irq_mask, stat_clr;

  ppt_regs #(.NPIN(NPIN), .NIRQ(NIRQ)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .pin_in(pin_in), .busy(busy), .rdback(rdback),
    .irq_stat(irq_stat), .irq_lvl(irq_lvl),
    .mode(mode), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .launch_wr(launch_wr), .launch_rd(launch_rd),
    .irq_mask(irq_mask), .stat_clr(stat_clr)
  );

  ppt_bus_seq #(.STROBE(STROBE), .ALE_CYC(2)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch_wr(launch_wr), .launch_rd(launch_rd),
    .addr(bus_addr), .wdata(bus_wdata), .ad_in(pin_in[AD_W-1:0]),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(bus_ale),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .busy(busy), .rdback(rdback)
  );

  ppt_irq #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .int_in(int_in), .clr(stat_clr),
    .stat(irq_stat), .lvl(irq_lvl)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i < AD_W) begin : g_ad
      assign pin_out[i] = mode ? ad_out[i] : gpio_out[i];
      assign pin_oe[i]  = mode ? ad_oe     : gpio_oe[i];
    end else if (i == PIN_ALE) begin : g_ale
      assign pin_out[i] = mode ? bus_ale : gpio_out[i];
      assign pin_oe[i]  = mode | gpio_oe[i];
    end else if (i == PIN_RDN) begin : g_rdn
      assign pin_out[i] = mode ? bus_rd_n : gpio_out[i];
      assign pin_oe[i]  = mode | gpio_oe[i];
    end else if (i == PIN_WRN) begin : g_wrn
      assign pin_out[i] = mode ? bus_wr_n : gpio_out[i];
      assign pin_oe[i]  = mode | gpio_oe[i];
    end else begin : g_gp
      assign pin_out[i] = gpio_out[i];
      assign pin_oe[i]  = gpio_oe[i];
    end
  end

  assign irq = |(irq_stat & irq_mask);

endmodule

// File: rtl/periph_port_chk.sv
module periph_port_chk #(
  parameter int unsigned NIRQ = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            busy,
  input logic            mode,
  input logic            irq,
  input logic [NIRQ-1:0] irq_stat,
  input logic [NIRQ-1:0] irq_mask,
  input logic            hst_wr,
  input logic [3:0]      hst_addr
);

  // R7: never both data strobes at once
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4: address phase keeps both data strobes high
  a_r4_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R4: address strobe lasts two clocks
  a_r4_ale_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);

  a_r4_ale_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);

  // R6: any bus activity implies busy
  a_r6_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !rd_n || !wr_n) |-> busy);

  // R12: mode frozen across busy
  a_r12_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(mode));

  // R9: status falls only after a host write to the status offset
  a_r9_stat_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq_stat) & ~irq_stat)) |-> $past(hst_wr && (hst_addr == 4'd8)));

  // R10: no request with all masks clear
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

endmodule

bind periph_port periph_port_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ale(bus_ale), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
  .busy(busy), .mode(mode), .irq(irq),
  .irq_stat(irq_stat), .irq_mask(irq_mask),
  .hst_wr(hst_wr), .hst_addr(hst_addr)
);

// File: tb/periph_port_bench.sv
module periph_port_bench;

  localparam int NPIN = 11;
  localparam int NIRQ = 2;

  logic            clk;
  logic            rst_n;
  logic            hst_wr, hst_rd;
  logic [3:0]      hst_addr;
  logic [NPIN-1:0] hst_wdata, hst_rdata, pin_in, pin_out, pin_oe;
  logic [NIRQ-1:0] int_in;
  logic            irq;

  periph_port u_periph_port (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .int_in(int_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  logic  probe_v;
  int    n_chk, n_err;
  bit    done;

  // monitor: sel 0 = read data, 1 = {oe, out}, 2 = irq
  always @(negedge clk) begin
    if (probe_v && !done) begin
      if (sbq.size() == 0) begin
        n_err++;
        $display("FAIL scoreboard empty");
      end else begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.sel)
          0:       act = 32'(hst_rdata);
          1:       act = {10'd0, pin_oe, pin_out};
          default: act = {31'd0, irq};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_item(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    probe_v = 1'b1;
    tick();
    probe_v = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    hst_addr = a;
    expect_item(0, exp, tag);
  endtask

  task automatic pins_chk(input logic [10:0] oe, input logic [10:0] o, input string tag);
    expect_item(1, {10'd0, oe, o}, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [NPIN-1:0] d);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    tick();
    hst_wr = 1'b0;
  endtask

  function automatic string finish_line();
    return $sformatf("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("%s", finish_line());
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0; probe_v = 1'b0;
    rst_n = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = 4'd0;
    hst_wdata = '0; pin_in = '0; int_in = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd_chk(4'd0, 0, "R1 mode");
    pins_chk(11'h000, 11'h000, "R1 pins");
    rd_chk(4'd7, 0, "R1 busy");
    expect_item(2, 0, "R1 irq");

    // R2 GPIO drive
    wr(4'd1, 11'h5A3);
    wr(4'd2, 11'h0F0);
    pins_chk(11'h0F0, 11'h5A3, "R2 gpio pins");
    rd_chk(4'd1, 11'h5A3, "R2 out readback");
    rd_chk(4'd2, 11'h0F0, "R2 oe readback");

    // R3 live pin level
    pin_in = 11'h2C5;
    rd_chk(4'd3, 11'h2C5, "R3 pin level");
    pin_in = 11'h13A;
    rd_chk(4'd3, 11'h13A, "R3 pin level 2");

    // R8 data access in GPIO mode
    wr(4'd4, 11'h3C);
    wr(4'd5, 11'h77);
    rd_chk(4'd7, 0, "R8 no busy");
    pins_chk(11'h0F0, 11'h5A3, "R8 pins unchanged");

    // R7 bus idle
    wr(4'd0, 11'h1);
    pins_chk(11'h700, 11'h600, "R7 bus idle");

    // R4 bus write, with ignored accesses (R6, R12)
    hst_addr = 4'd5; hst_wdata = 11'hA5; hst_wr = 1'b1;
    tick();
    hst_wr = 1'b0;
    pins_chk(11'h7FF, 11'h73C, "R4 ale 1");
    pins_chk(11'h7FF, 11'h73C, "R4 ale 2");
    hst_addr = 4'd5; hst_wdata = 11'h11; hst_wr = 1'b1;
    expect_item(1, {10'd0, 11'h7FF, 11'h2A5}, "R4 wr 1");
    hst_addr = 4'd0; hst_wdata = 11'h0;
    expect_item(1, {10'd0, 11'h7FF, 11'h2A5}, "R4 wr 2");
    hst_wr = 1'b0;
    pins_chk(11'h7FF, 11'h2A5, "R4 wr 3");
    pins_chk(11'h700, 11'h600, "R6 no restart after ignored write");
    pins_chk(11'h700, 11'h600, "R6 still idle");
    rd_chk(4'd0, 1, "R12 mode kept");

    // R6 busy length
    wr(4'd5, 11'h42);
    rd_chk(4'd7, 1, "R6 busy set");
    repeat (4) tick();
    rd_chk(4'd7, 0, "R6 busy clear");

    // R5 bus read
    wr(4'd4, 11'h81);
    hst_addr = 4'd5; hst_rd = 1'b1;
    tick();
    hst_rd = 1'b0;
    pins_chk(11'h7FF, 11'h781, "R5 ale 1");
    pins_chk(11'h7FF, 11'h781, "R5 ale 2");
    pin_in = 11'h033;
    pins_chk(11'h700, 11'h400, "R5 rd 1");
    pin_in = 11'h066;
    pins_chk(11'h700, 11'h400, "R5 rd 2");
    pin_in = 11'h0C9;
    pins_chk(11'h700, 11'h400, "R5 rd 3");
    pin_in = 11'h000;
    rd_chk(4'd6, 11'h0C9, "R5 readback last clock");
    pins_chk(11'h700, 11'h600, "R5 released");

    // R9 R10 R11 interrupts
    wr(4'd9, 11'h1);
    int_in = 2'b01;
    repeat (4) tick();
    rd_chk(4'd8, 1, "R9 rise sets");
    expect_item(2, 1, "R10 irq high");
    rd_chk(4'd10, 1, "R11 level");
    wr(4'd8, 11'h1);
    rd_chk(4'd8, 0, "R9 w1c");
    expect_item(2, 0, "R10 irq low");
    int_in = 2'b00;
    repeat (4) tick();
    rd_chk(4'd8, 1, "R9 fall sets");
    wr(4'd8, 11'h1);
    int_in = 2'b10;
    repeat (4) tick();
    rd_chk(4'd8, 2, "R9 input 1");
    expect_item(2, 0, "R10 masked");
    rd_chk(4'd10, 2, "R11 level 2");

    done = 1'b1;
    $display("%s", finish_line());
    $finish;
  end

endmodule